// File: doc/BRIEF.md
# Boundary-Scan Register Chain

This block is the boundary-scan register of a small device that has input pins, output pins and bidirectional pins. Each pin has a scan cell, and each bidirectional pin has two: one for data and one for the output enable. Every cell holds two bits of state. The first is a capture/shift bit, clocked on the rising edge of the test clock. The second is a parallel update bit, clocked on the falling edge. The capture, shift and update strobes come from an external TAP controller. The instruction decoder supplies a test-mode select and a bidirectional force-to-input control.

When test mode is off, functional data passes straight between pins and core, and the device runs undisturbed. Capture works the same way whatever the test mode, so a snapshot of the device boundary can be taken at any time. A safe pattern can be shifted in and moved into the update bits while the device is still running normally. That pattern reaches the pins only once test mode is switched on. A test-logic-reset input clears every update bit, which leaves every bidirectional pin undriven.

Top module: `bsr_chain`

## Requirements
- R1: With `mode`=0, `in_core`=`in_pin`, `out_pin`=`out_core`, `bd_pin_out`=`bd_core_out`, `bd_core_in`=`bd_pin_in`, and (when not forced) `bd_pin_oe`=`bd_core_oe`.
- R2: A rising `tck` edge with `capture_dr`=1 loads the capture bits, whatever the value of `mode`. Chain bit i < N_IN takes `in_pin[i]`. Bit N_IN+k takes `out_core[k]`. For bidirectional pin j, bit N_IN+N_OUT+2j takes `bd_pin_in[j]` and bit N_IN+N_OUT+2j+1 takes `bd_core_oe[j]`. Capture has priority over shift.
- R3: On each rising `tck` edge with `shift_dr`=1, the chain moves one place toward `tdo`, and `tdi` enters the highest bit. `tdo` always shows bit 0, so bit k of the chain leaves first after k shift edges.
- R4: The update bits load the capture/shift bits only on a falling `tck` edge with `update_dr`=1. At any other time, including while shifting, they hold their value.
- R5: With `mode`=1, each output is taken from the update bit of its cell, using the R2 layout. `in_core` and `out_pin` come from their own cells. `bd_pin_out` and `bd_core_in` come from the data cell, and `bd_pin_oe` comes from the control cell.
- R6: With `bidir_as_input`=1, every `bd_pin_oe` is 0, whatever the values of `mode` and the update bits.
- R7: `tlr`=1 clears every update bit (synchronously, on the falling edge) and every capture/shift bit (on the rising edge). With `mode`=1, all outputs then read 0 and all enables are off.
- R8: A pattern that is shifted and updated while `mode`=0 leaves every pin output unchanged. It appears on the pins once `mode` becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tlr | input | 1 | Test-logic-reset, synchronous, active high |
| tdi | input | 1 | Serial data in |
| capture_dr | input | 1 | Capture strobe |
| shift_dr | input | 1 | Shift strobe |
| update_dr | input | 1 | Update strobe |
| mode | input | 1 | 1 selects test data at the pin and core muxes |
| bidir_as_input | input | 1 | Forces all bidirectional enables off |
| in_pin | input | N_IN | Values at the input pins |
| in_core | output | N_IN | Input values passed to the core |
| out_core | input | N_OUT | Core values for the output pins |
| out_pin | output | N_OUT | Values driven to the output pins |
| bd_pin_in | input | N_BIDIR | Values received at the bidirectional pads |
| bd_core_out | input | N_BIDIR | Core data for the bidirectional pins |
| bd_core_oe | input | N_BIDIR | Core output enables for the bidirectional pins |
| bd_pin_out | output | N_BIDIR | Data driven to the bidirectional pads |
| bd_pin_oe | output | N_BIDIR | Output enables of the bidirectional pads |
| bd_core_in | output | N_BIDIR | Bidirectional input values passed to the core |
| tdo | output | 1 | Serial data out (chain bit 0) |

## Verification
A wrong capture or shift bit is not visible at once. It appears at `tdo` during the shift that follows, at the position of that cell in the chain, so it is seen within one chain length of shift edges. A wrong update bit shows at the pins only while `mode` is 1. If that bit was loaded on the wrong edge, the error appears half a `tck` period early, while a pattern is still being shifted. The bench sweeps every scan pattern of a six-cell chain, alternates `mode` during capture and update, and reads the result both at `tdo` and at the pins.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

  typedef enum logic [1:0] {
    CELL_IN      = 2'd0,
    CELL_OUT     = 2'd1,
    CELL_BD_DATA = 2'd2,
    CELL_BD_CTL  = 2'd3
  } cell_kind_e;

  function automatic int chain_len(input int n_in, input int n_out, input int n_bd);
    return n_in + n_out + 2 * n_bd;
  endfunction

  function automatic cell_kind_e kind_of(input int idx, input int n_in, input int n_out);
    if (idx < n_in) return CELL_IN;
    if (idx < n_in + n_out) return CELL_OUT;
    if (((idx - n_in - n_out) % 2) == 0) return CELL_BD_DATA;
    return CELL_BD_CTL;
  endfunction

endpackage

// File: rtl/bsr_capture_shift.sv
module bsr_capture_shift #(
  parameter int LEN = 8
) (
  input  logic           tck,
  input  logic           tlr,
  input  logic           capture_dr,
  input  logic           shift_dr,
  input  logic           tdi,
  input  logic [LEN-1:0] cap_vec,
  output logic [LEN-1:0] shift_q
);

  always_ff @(posedge tck) begin
    if (tlr) begin
      shift_q <= '0;
    end else if (capture_dr) begin
      shift_q <= cap_vec;
    end else if (shift_dr) begin
      if (LEN > 1) shift_q <= {tdi, shift_q[LEN-1:1]};
      else         shift_q <= tdi;
    end
  end

endmodule

// File: rtl/bsr_update.sv
module bsr_update #(
  parameter int LEN = 8
) (
  input  logic           tck,
  input  logic           tlr,
  input  logic           update_dr,
  input  logic [LEN-1:0] shift_q,
  output logic [LEN-1:0] upd_q
);

  // Falling-edge stage: pins never move while the shift stage is moving.
  always_ff @(negedge tck) begin
    if (tlr)            upd_q <= '0;
    else if (update_dr) upd_q <= shift_q;
  end

endmodule

// File: rtl/bsr_cell_map.sv
module bsr_cell_map
  import bsr_pkg::*;
#(
  parameter int N_IN    = 4,
  parameter int N_OUT   = 4,
  parameter int N_BIDIR = 2,
  localparam int LEN    = chain_len(N_IN, N_OUT, N_BIDIR)
) (
  input  logic               mode,
  input  logic               bidir_as_input,
  input  logic [LEN-1:0]     upd_q,
  input  logic [N_IN-1:0]    in_pin,
  input  logic [N_OUT-1:0]   out_core,
  input  logic [N_BIDIR-1:0] bd_pin_in,
  input  logic [N_BIDIR-1:0] bd_core_out,
  input  logic [N_BIDIR-1:0] bd_core_oe,
  output logic [LEN-1:0]     cap_vec,
  output logic [N_IN-1:0]    in_core,
  output logic [N_OUT-1:0]   out_pin,
  output logic [N_BIDIR-1:0] bd_pin_out,
  output logic [N_BIDIR-1:0] bd_pin_oe,
  output logic [N_BIDIR-1:0] bd_core_in
);

  localparam int BD_BASE = N_IN + N_OUT;

  // Capture sources: independent of mode.
  for (genvar i = 0; i < LEN; i++) begin : g_cap
    localparam cell_kind_e KIND = kind_of(i, N_IN, N_OUT);
    if (KIND == CELL_IN) begin : g_in
      assign cap_vec[i] = in_pin[i];
    end else if (KIND == CELL_OUT) begin : g_out
      assign cap_vec[i] = out_core[i - N_IN];
    end else if (KIND == CELL_BD_DATA) begin : g_bdd
      assign cap_vec[i] = bd_pin_in[(i - BD_BASE) / 2];
    end else begin : g_bdc
      assign cap_vec[i] = bd_core_oe[(i - BD_BASE) / 2];
    end
  end

  for (genvar k = 0; k < N_IN; k++) begin : g_in_mux
    assign in_core[k] = mode ? upd_q[k] : in_pin[k];
  end

  for (genvar k = 0; k < N_OUT; k++) begin : g_out_mux
    assign out_pin[k] = mode ? upd_q[N_IN + k] : out_core[k];
  end

  for (genvar j = 0; j < N_BIDIR; j++) begin : g_bd_mux
    localparam int DIDX = BD_BASE + 2 * j;
    localparam int CIDX = DIDX + 1;
    assign bd_pin_out[j] = mode ? upd_q[DIDX] : bd_core_out[j];
    assign bd_core_in[j] = mode ? upd_q[DIDX] : bd_pin_in[j];
    assign bd_pin_oe[j]  = bidir_as_input ? 1'b0
                         : (mode ? upd_q[CIDX] : bd_core_oe[j]);
  end

endmodule

// File: rtl/bsr_chain.sv
module bsr_chain
  import bsr_pkg::*;
#(
  parameter int N_IN    = 4,
  parameter int N_OUT   = 4,
  parameter int N_BIDIR = 2
) (
  input  logic               tck,
  input  logic               tlr,
  input  logic               tdi,
  input  logic               capture_dr,
  input  logic               shift_dr,
  input  logic               update_dr,
  input  logic               mode,
  input  logic               bidir_as_input,
  input  logic [N_IN-1:0]    in_pin,
  output logic [N_IN-1:0]    in_core,
  input  logic [N_OUT-1:0]   out_core,
  output logic [N_OUT-1:0]   out_pin,
  input  logic [N_BIDIR-1:0] bd_pin_in,
  input  logic [N_BIDIR-1:0] bd_core_out,
  input  logic [N_BIDIR-1:0] bd_core_oe,
  output logic [N_BIDIR-1:0] bd_pin_out,
  output logic [N_BIDIR-1:0] bd_pin_oe,
  output logic [N_BIDIR-1:0] bd_core_in,
  output logic               tdo
);

  localparam int LEN = chain_len(N_IN, N_OUT, N_BIDIR);

  logic [LEN-1:0] cap_vec;
  logic [LEN-1:0] shift_q;
  logic [LEN-1:0] upd_q;

  bsr_capture_shift #(.LEN(LEN)) u_shift (
    .tck        (tck),
    .tlr        (tlr),
    .capture_dr (capture_dr),
    .shift_dr   (shift_dr),
    .tdi        (tdi),
    .cap_vec    (cap_vec),
    .shift_q    (shift_q)
  );

  bsr_update #(.LEN(LEN)) u_update (
    .tck       (tck),
    .tlr       (tlr),
    .update_dr (update_dr),
    .shift_q   (shift_q),
    .upd_q     (upd_q)
  );

  bsr_cell_map #(.N_IN(N_IN), .N_OUT(N_OUT), .N_BIDIR(N_BIDIR)) u_map (
    .mode           (mode),
    .bidir_as_input (bidir_as_input),
    .upd_q          (upd_q),
    .in_pin         (in_pin),
    .out_core       (out_core),
    .bd_pin_in      (bd_pin_in),
    .bd_core_out    (bd_core_out),
    .bd_core_oe     (bd_core_oe),
    .cap_vec        (cap_vec),
    .in_core        (in_core),
    .out_pin        (out_pin),
    .bd_pin_out     (bd_pin_out),
    .bd_pin_oe      (bd_pin_oe),
    .bd_core_in     (bd_core_in)
  );

  assign tdo = shift_q[0];

endmodule

// File: rtl/bsr_chain_chk.sv
module bsr_chain_chk #(
  parameter int N_IN    = 4,
  parameter int N_OUT   = 4,
  parameter int N_BIDIR = 2,
  localparam int LEN    = N_IN + N_OUT + 2 * N_BIDIR
) (
  input logic               tck,
  input logic               tlr,
  input logic               capture_dr,
  input logic               shift_dr,
  input logic               update_dr,
  input logic               mode,
  input logic               bidir_as_input,
  input logic [N_IN-1:0]    in_pin,
  input logic [N_IN-1:0]    in_core,
  input logic [N_OUT-1:0]   out_core,
  input logic [N_OUT-1:0]   out_pin,
  input logic [N_BIDIR-1:0] bd_pin_oe,
  input logic [LEN-1:0]     cap_vec,
  input logic [LEN-1:0]     shift_q,
  input logic [LEN-1:0]     upd_q,
  input logic               tdo
);

  assert_passthrough_R1: assert property (@(posedge tck) disable iff (tlr)
    !mode |-> (in_core == in_pin && out_pin == out_core));

  assert_capture_R2: assert property (@(posedge tck) disable iff (tlr)
    capture_dr |=> shift_q == $past(cap_vec));

  if (LEN > 1) begin : g_shift_chk
    assert_shift_R3: assert property (@(posedge tck) disable iff (tlr)
      (shift_dr && !capture_dr) |=> tdo == $past(shift_q[1]));
  end

  assert_update_hold_R4: assert property (@(negedge tck) disable iff (tlr)
    !update_dr |=> $stable(upd_q));

  assert_force_input_R6: assert property (@(posedge tck) disable iff (tlr)
    bidir_as_input |-> bd_pin_oe == '0);

endmodule

bind bsr_chain bsr_chain_chk #(.N_IN(N_IN), .N_OUT(N_OUT), .N_BIDIR(N_BIDIR)) u_chk (
  .tck            (tck),
  .tlr            (tlr),
  .capture_dr     (capture_dr),
  .shift_dr       (shift_dr),
  .update_dr      (update_dr),
  .mode           (mode),
  .bidir_as_input (bidir_as_input),
  .in_pin         (in_pin),
  .in_core        (in_core),
  .out_core       (out_core),
  .out_pin        (out_pin),
  .bd_pin_oe      (bd_pin_oe),
  .cap_vec        (cap_vec),
  .shift_q        (shift_q),
  .upd_q          (upd_q),
  .tdo            (tdo)
);

// File: tb/bsr_chain_tb.sv
module bsr_chain_tb;

  localparam int NI = 2, NO = 2, NB = 1, L = 6;

  logic tck = 1'b0;
  logic tlr = 1'b1, tdi = 1'b0, capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0;
  logic mode = 1'b0, bidir_as_input = 1'b0;
  logic [NI-1:0] in_pin = '0, in_core;
  logic [NO-1:0] out_core = '0, out_pin;
  logic [NB-1:0] bd_pin_in = '0, bd_core_out = '0, bd_core_oe = '0;
  logic [NB-1:0] bd_pin_out, bd_pin_oe, bd_core_in;
  logic tdo;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 tck = ~tck;

  bsr_chain #(.N_IN(NI), .N_OUT(NO), .N_BIDIR(NB)) u_dut (
    .tck(tck), .tlr(tlr), .tdi(tdi), .capture_dr(capture_dr), .shift_dr(shift_dr),
    .update_dr(update_dr), .mode(mode), .bidir_as_input(bidir_as_input),
    .in_pin(in_pin), .in_core(in_core), .out_core(out_core), .out_pin(out_pin),
    .bd_pin_in(bd_pin_in), .bd_core_out(bd_core_out), .bd_core_oe(bd_core_oe),
    .bd_pin_out(bd_pin_out), .bd_pin_oe(bd_pin_oe), .bd_core_in(bd_core_in), .tdo(tdo)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Advance to 5 ns after a rising edge (drive point).
  task automatic tick();
    @(posedge tck);
    #5;
  endtask

  // Pin view in test mode, per the R5 layout: {oe, core_in, pin_out, out_pin, in_core}
  function automatic logic [31:0] exp_test(input logic [5:0] p);
    return {25'd0, p[5], p[4], p[4], p[3:2], p[1:0]};
  endfunction

  function automatic logic [31:0] obs();
    return {25'd0, bd_pin_oe, bd_core_in, bd_pin_out, out_pin, in_core};
  endfunction

  task automatic scan(input logic [L-1:0] din, output logic [L-1:0] dout);
    for (int k = 0; k < L; k++) begin
      tick();
      shift_dr = 1'b1;
      tdi = din[k];
      #10;
      dout[k] = tdo;
    end
    tick();
    shift_dr = 1'b0;
    tdi = 1'b0;
  endtask

  task automatic do_capture();
    tick(); capture_dr = 1'b1;
    tick(); capture_dr = 1'b0;
  endtask

  task automatic do_update();
    tick(); update_dr = 1'b1;
    tick(); update_dr = 1'b0;
  endtask

  initial begin
    logic [L-1:0] dout;
    logic [5:0] s;
    logic [5:0] prev;
    mode = 1'b1;
    repeat (3) tick();
    #10;
    // R7: everything cleared, enables off in test mode
    chk(obs(), 32'd0, "R7");
    chk({31'd0, tdo}, 32'd0, "R7");
    tick();
    tlr = 1'b0;
    mode = 1'b0;

    // R1: full sweep of the functional path
    for (int v = 0; v < 128; v++) begin
      tick();
      {bd_core_oe, bd_core_out, bd_pin_in, out_core, in_pin} = 7'(v);
      #10;
      chk({30'd0, in_core}, {30'd0, in_pin}, "R1");
      chk({30'd0, out_pin}, {30'd0, out_core}, "R1");
      chk({29'd0, bd_pin_out, bd_core_in, bd_pin_oe},
          {29'd0, bd_core_out, bd_pin_in, bd_core_oe}, "R1");
    end

    prev = '0;
    for (int p = 0; p < 64; p++) begin
      s = 6'(p) ^ 6'h2A;
      tick();
      mode = p[0];
      in_pin = s[1:0]; out_core = s[3:2]; bd_pin_in = s[4]; bd_core_oe = s[5];
      bd_core_out = s[0];
      do_capture();
      scan(6'(p), dout);
      // R2 and R3: captured snapshot leaves tdo bit 0 first
      chk({26'd0, dout}, {26'd0, s}, "R2_R3");
      // R4: update bits untouched by shifting
      tick(); mode = 1'b1;
      #10;
      chk(obs(), exp_test(prev), "R4");
      tick(); mode = p[1];
      do_update();
      #10;
      if (!p[1]) begin
        // R8: preloaded while running, pins still functional
        chk({30'd0, out_pin}, {30'd0, out_core}, "R8");
        chk({30'd0, in_core}, {30'd0, in_pin}, "R8");
        tick(); mode = 1'b1;
        #10;
      end
      // R5 / R8: pattern on pins in test mode
      chk(obs(), exp_test(6'(p)), "R5");
      tick(); bidir_as_input = 1'b1;
      #10;
      chk({31'd0, bd_pin_oe}, 32'd0, "R6");
      tick(); bidir_as_input = 1'b0;
      prev = 6'(p);
    end

    // R7: reset in mid-operation clears pins in test mode
    tick(); tlr = 1'b1; mode = 1'b1;
    tick(); tlr = 1'b0;
    #10;
    chk(obs(), 32'd0, "R7");

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule